// File: doc/BRIEF.md
# Serial Port Interrupt Enable Controller

This block sits beside a UART datapath and turns its event conditions into an interrupt status byte and an active-low interrupt request. The event conditions are receive FIFO at or above its trigger level, received character available, transmit holding register empty, modem status change, and a received character matching the programmed Xoff values. Software writes a byte-wide enable register. A separate master enable bit from the modem control register decides whether any pending source may pull the request line. Because the request is active-low, several ports can share one wired request line.

The status byte names only the most urgent pending source. Reading the status clears the Xoff event. The read also retires the transmit-empty event if that event was the one reported. One enable bit does not select an interrupt source: it asks for sleep. The sleep request is honoured only while nothing is pending, and the enable register keeps its value through sleep.

Top module: `uart_irq_ctl`

## Requirements
- R1: After reset the enable register reads 0x00, the status reads 0x01, `irq_n` is 1 and `sleep_active` is 0. A write strobe loads `ier_wdata` into the enable register, and the new value shows on `ier_q` after that clock edge.
- R2: With enable bit 0 set, the receive-trigger source is pending (status 0x04) while both `rx_trig` and `fifo_en` are 1. It stops pending as soon as `rx_trig` falls. With `fifo_en` at 0, `rx_trig` has no effect.
- R3: With enable bit 2 set, a high `rx_avail` makes the status 0x04, and the status returns to 0x01 when `rx_avail` falls.
- R4: With enable bit 1 set, a high `thr_empty` makes the status 0x02. A status read that reports 0x02 retires this source until the next `thr_wr` pulse re-arms it.
- R5: With enable bit 3 set, a high `modem_chg` makes the status 0x00.
- R6: With enable bit 5 set, `flow_en` 1 and `xoff_pair` 0, a received character equal to `xoff1` latches an Xoff event, which shows as status 0x10. Any status read clears the event. With `flow_en` 0, no character latches the event.
- R7: With `xoff_pair` 1, the Xoff event latches only when a character equal to `xoff2` is the received character that immediately follows one equal to `xoff1`. A lone `xoff1`, or any other character in between, latches nothing.
- R8: When several sources are pending, the status reports the highest of receive (0x04), then Xoff (0x10), then transmit empty (0x02), then modem (0x00). The status only ever takes one of these codes or 0x01.
- R9: `irq_n` is 0 exactly when some source is pending and `mcr_irq_en` is 1. The status code does not depend on `mcr_irq_en`.
- R10: When enable bits 7..5 and 3..0 are all 0, the status reads 0x01 and `irq_n` is 1, whatever the event inputs are.
- R11: `sleep_active` becomes 1 one clock after enable bit 4 is 1 while nothing is pending. It drops one clock after a source becomes pending. Entering or leaving sleep does not change the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_q | output | 8 | Enable register contents |
| mcr_irq_en | input | 1 | Master interrupt enable from the modem control register |
| fifo_en | input | 1 | Receive FIFO enabled |
| rx_trig | input | 1 | Receive FIFO fill at or above trigger level |
| rx_avail | input | 1 | Assembled received character available |
| thr_empty | input | 1 | Transmit holding register empty |
| thr_wr | input | 1 | Write strobe to the transmit holding register |
| modem_chg | input | 1 | Modem status change |
| flow_en | input | 1 | Software flow control on |
| xoff_pair | input | 1 | 1: two-character Xoff sequence, 0: single character |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | CHAR_W | Received character |
| xoff1 | input | CHAR_W | First Xoff character |
| xoff2 | input | CHAR_W | Second Xoff character |
| isr_rd | input | 1 | Status read strobe |
| isr_q | output | 8 | Interrupt status code |
| irq_n | output | 1 | Active-low interrupt request |
| sleep_active | output | 1 | Sleep granted |

## Verification
Several properties are checked on every cycle:
- The request line agrees with the master enable and the status "nothing pending" bit.
- The status stays idle while every source enable is clear.
- The status only takes legal codes.
- Sleep is granted only after a cycle in which nothing was pending.
- Enable writes land on the next cycle.
- A single-character Xoff match always leaves something pending.

Only the directed scenarios can show the rest:
- The exact order of priority among stacked sources.
- Clear-on-read retiring transmit-empty, and its re-arming by a holding-register write.
- A broken two-character Xoff sequence latching nothing.
- The receive-trigger source ignoring `rx_trig` while the FIFO is disabled.

// File: rtl/uart_irq_pkg.sv
// Shared constants for the interrupt controller: enable bit positions,
// source indices in priority order, and status codes.
package uart_irq_pkg;
    localparam int IER_W   = 8;
    localparam int ISR_W   = 8;
    localparam int NSRC    = 4;

    // enable register bit positions
    localparam int EN_RXTRIG = 0;
    localparam int EN_THR    = 1;
    localparam int EN_RXAV   = 2;
    localparam int EN_MODEM  = 3;
    localparam int EN_SLEEP  = 4;
    localparam int EN_XOFF   = 5;

    // source index doubles as priority rank, 0 is most urgent
    typedef enum int {
        SRC_RX   = 0,
        SRC_XOFF = 1,
        SRC_THR  = 2,
        SRC_MDM  = 3
    } src_e;

    localparam logic [ISR_W-1:0] ISR_NONE = 8'h01;
    localparam logic [ISR_W-1:0] ISR_RX   = 8'h04;
    localparam logic [ISR_W-1:0] ISR_XOFF = 8'h10;
    localparam logic [ISR_W-1:0] ISR_THR  = 8'h02;
    localparam logic [ISR_W-1:0] ISR_MDM  = 8'h00;

    // status code reported for a given source index
    function automatic logic [ISR_W-1:0] src_code(input int idx);
        case (idx)
            SRC_RX:   src_code = ISR_RX;
            SRC_XOFF: src_code = ISR_XOFF;
            SRC_THR:  src_code = ISR_THR;
            default:  src_code = ISR_MDM;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_xoff.sv
// Xoff character matcher.
// Latches an event when a received character equals xoff1 (single mode)
// or when xoff2 arrives as the very next character after xoff1 (pair mode).
// The event is held until a clear strobe; a new match in the same cycle
// as the clear wins. Assumes rx_valid is a one-cycle strobe per character.
module uart_irq_xoff #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_en,
    input  logic              pair_mode,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    input  logic              clr,
    output logic              hit
);
    logic seen_first;
    logic is_first;
    logic is_second;
    logic match;

    // decode this character against both programmed values
    always_comb begin
        is_first  = (rx_char == xoff1);
        is_second = (rx_char == xoff2);
        match     = flow_en && rx_valid &&
                    (pair_mode ? (seen_first && is_second) : is_first);
    end

    // track the sequence state and hold the latched event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_first <= 1'b0;
            hit        <= 1'b0;
        end else begin
            if (!flow_en || !pair_mode)
                seen_first <= 1'b0;
            else if (rx_valid)
                seen_first <= is_first;
            if (match)
                hit <= 1'b1;
            else if (clr)
                hit <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority encoder: maps a vector of pending sources (index 0 most
// urgent) onto the status code of the winner, or the idle code.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]     pend,
    output logic [ISR_W-1:0] code,
    output logic             any
);
    // scan from least to most urgent so the most urgent assignment stands
    always_comb begin
        code = ISR_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i])
                code = src_code(i);
        end
        any = |pend;
    end
endmodule

// File: rtl/uart_irq_ctl.sv
// Per-port interrupt enable controller.
// Holds the enable register, qualifies each event with its enable bit,
// keeps the clear-on-read state of the Xoff and transmit-empty sources,
// drives the status code and the active-low request, and grants sleep
// only while nothing is pending. Assumes event inputs are synchronous
// to clk and that strobes last one cycle.
module uart_irq_ctl
    import uart_irq_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ier_wr,
    input  logic [IER_W-1:0]  ier_wdata,
    output logic [IER_W-1:0]  ier_q,
    input  logic              mcr_irq_en,
    input  logic              fifo_en,
    input  logic              rx_trig,
    input  logic              rx_avail,
    input  logic              thr_empty,
    input  logic              thr_wr,
    input  logic              modem_chg,
    input  logic              flow_en,
    input  logic              xoff_pair,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    input  logic              isr_rd,
    output logic [ISR_W-1:0]  isr_q,
    output logic              irq_n,
    output logic              sleep_active
);
    logic [NSRC-1:0] pend;
    logic            any_pend;
    logic            xoff_hit;
    logic            thr_armed;

    // enable register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ier_q <= '0;
        else if (ier_wr)
            ier_q <= ier_wdata;
    end

    // transmit-empty arming: retired by a read reporting it, re-armed by a write
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_armed <= 1'b1;
        else if (thr_wr)
            thr_armed <= 1'b1;
        else if (isr_rd && isr_q == ISR_THR)
            thr_armed <= 1'b0;
    end

    // Xoff match detector, cleared by any status read
    uart_irq_xoff #(.CHAR_W(CHAR_W)) u_xoff (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_en   (flow_en),
        .pair_mode (xoff_pair),
        .rx_valid  (rx_valid),
        .rx_char   (rx_char),
        .xoff1     (xoff1),
        .xoff2     (xoff2),
        .clr       (isr_rd),
        .hit       (xoff_hit)
    );

    // qualify each source with its enable bit
    always_comb begin
        pend[SRC_RX]   = (ier_q[EN_RXTRIG] && fifo_en && rx_trig) ||
                         (ier_q[EN_RXAV] && rx_avail);
        pend[SRC_XOFF] = ier_q[EN_XOFF] && xoff_hit;
        pend[SRC_THR]  = ier_q[EN_THR] && thr_empty && thr_armed;
        pend[SRC_MDM]  = ier_q[EN_MODEM] && modem_chg;
    end

    uart_irq_prio #(.N(NSRC)) u_prio (
        .pend (pend),
        .code (isr_q),
        .any  (any_pend)
    );

    // request line needs the master enable as well
    always_comb irq_n = !(any_pend && mcr_irq_en);

    // sleep grant: requested and nothing pending in the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            sleep_active <= 1'b0;
        else
            sleep_active <= ier_q[EN_SLEEP] && !any_pend;
    end
endmodule

// File: rtl/uart_irq_chk.sv
// Property checker for uart_irq_ctl, attached through bind.
module uart_irq_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ier_wr,
    input logic [7:0]        ier_wdata,
    input logic [7:0]        ier_q,
    input logic              mcr_irq_en,
    input logic              flow_en,
    input logic              xoff_pair,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_char,
    input logic [CHAR_W-1:0] xoff1,
    input logic [7:0]        isr_q,
    input logic              irq_n,
    input logic              sleep_active
);
    assert_ier_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> ier_q == $past(ier_wdata));

    assert_xoff_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && !xoff_pair && rx_valid && rx_char == xoff1 &&
         ier_q[5] && !ier_wr) |=> !isr_q[0]);

    assert_legal_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        isr_q == 8'h01 || isr_q == 8'h04 || isr_q == 8'h10 ||
        isr_q == 8'h02 || isr_q == 8'h00);

    assert_req_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n) == (mcr_irq_en && !isr_q[0]));

    assert_idle_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[7:5] == 3'b000 && ier_q[3:0] == 4'b0000) |->
        (isr_q == 8'h01 && irq_n));

    assert_sleep_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_active |-> $past(isr_q[0] && ier_q[4]));
endmodule

bind uart_irq_ctl uart_irq_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ier_wr       (ier_wr),
    .ier_wdata    (ier_wdata),
    .ier_q        (ier_q),
    .mcr_irq_en   (mcr_irq_en),
    .flow_en      (flow_en),
    .xoff_pair    (xoff_pair),
    .rx_valid     (rx_valid),
    .rx_char      (rx_char),
    .xoff1        (xoff1),
    .isr_q        (isr_q),
    .irq_n        (irq_n),
    .sleep_active (sleep_active)
);

// File: tb/sim_uart_irq_ctl.sv
// Directed bench: inputs change on falling edges, outputs sampled mid-cycle.
module sim_uart_irq_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 1'b0;
    logic [7:0] ier_wdata = '0;
    logic [7:0] ier_q;
    logic       mcr_irq_en = 1'b0;
    logic       fifo_en = 1'b0;
    logic       rx_trig = 1'b0;
    logic       rx_avail = 1'b0;
    logic       thr_empty = 1'b0;
    logic       thr_wr = 1'b0;
    logic       modem_chg = 1'b0;
    logic       flow_en = 1'b0;
    logic       xoff_pair = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic [7:0] xoff1 = 8'h13;
    logic [7:0] xoff2 = 8'h93;
    logic       isr_rd = 1'b0;
    logic [7:0] isr_q;
    logic       irq_n;
    logic       sleep_active;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_irq_ctl u0 (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic wr_ier(input logic [7:0] v);
        @(negedge clk); ier_wdata = v; ier_wr = 1'b1;
        @(negedge clk); ier_wr = 1'b0;
    endtask

    task automatic rd_isr();
        @(negedge clk); isr_rd = 1'b1;
        @(negedge clk); isr_rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] c);
        @(negedge clk); rx_char = c; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic quiet();
        @(negedge clk);
        rx_trig = 0; rx_avail = 0; thr_empty = 0; modem_chg = 0;
        fifo_en = 0; flow_en = 0; xoff_pair = 0; mcr_irq_en = 1;
        rd_isr();
        wr_ier(8'h00);
    endtask

    task automatic t_reset();
        settle();
        chk("R1 reset ier", ier_q, 8'h00);
        chk("R1 reset isr", isr_q, 8'h01);
        chk("R1 reset irq_n", {7'd0, irq_n}, 8'h01);
        chk("R1 reset sleep", {7'd0, sleep_active}, 8'h00);
    endtask

    task automatic t_ier();
        wr_ier(8'hA5); settle();
        chk("R1 ier readback", ier_q, 8'hA5);
        wr_ier(8'h00); settle();
        chk("R1 ier rewrite", ier_q, 8'h00);
    endtask

    task automatic t_rxtrig();
        quiet(); wr_ier(8'h01);
        rx_trig = 1; settle();
        chk("R2 fifo off ignores trig", isr_q, 8'h01);
        fifo_en = 1; settle();
        chk("R2 trig pending", isr_q, 8'h04);
        chk("R2 trig irq_n", {7'd0, irq_n}, 8'h00);
        rx_trig = 0; settle();
        chk("R2 trig cleared", isr_q, 8'h01);
    endtask

    task automatic t_rxavail();
        quiet(); wr_ier(8'h04);
        rx_avail = 1; settle();
        chk("R3 avail pending", isr_q, 8'h04);
        rx_avail = 0; settle();
        chk("R3 avail cleared", isr_q, 8'h01);
    endtask

    task automatic t_thr();
        quiet(); wr_ier(8'h02);
        thr_empty = 1; settle();
        chk("R4 thr pending", isr_q, 8'h02);
        rd_isr(); settle();
        chk("R4 thr retired by read", isr_q, 8'h01);
        @(negedge clk); thr_wr = 1;
        @(negedge clk); thr_wr = 0; settle();
        chk("R4 thr rearmed", isr_q, 8'h02);
    endtask

    task automatic t_modem();
        quiet(); wr_ier(8'h08);
        modem_chg = 1; settle();
        chk("R5 modem code", isr_q, 8'h00);
        chk("R5 modem irq_n", {7'd0, irq_n}, 8'h00);
    endtask

    task automatic t_xoff_single();
        quiet(); wr_ier(8'h20);
        flow_en = 1; xoff_pair = 0;
        send(8'h41); settle();
        chk("R6 other char", isr_q, 8'h01);
        send(8'h13); settle();
        chk("R6 xoff match", isr_q, 8'h10);
        rd_isr(); settle();
        chk("R6 cleared by read", isr_q, 8'h01);
        flow_en = 0;
        send(8'h13); settle();
        chk("R6 flow off ignores", isr_q, 8'h01);
    endtask

    task automatic t_xoff_pair();
        quiet(); wr_ier(8'h20);
        flow_en = 1; xoff_pair = 1;
        send(8'h13); settle();
        chk("R7 first alone", isr_q, 8'h01);
        send(8'h93); settle();
        chk("R7 pair match", isr_q, 8'h10);
        rd_isr();
        send(8'h13); send(8'h41); send(8'h93); settle();
        chk("R7 broken sequence", isr_q, 8'h01);
    endtask

    task automatic t_prio();
        quiet(); wr_ier(8'h2F);
        flow_en = 1;
        modem_chg = 1; settle();
        chk("R8 modem only", isr_q, 8'h00);
        thr_empty = 1; settle();
        chk("R8 thr over modem", isr_q, 8'h02);
        send(8'h13); settle();
        chk("R8 xoff over thr", isr_q, 8'h10);
        rx_avail = 1; settle();
        chk("R8 rx over xoff", isr_q, 8'h04);
        rx_avail = 0; settle();
        chk("R8 back to xoff", isr_q, 8'h10);
    endtask

    task automatic t_master();
        quiet(); wr_ier(8'h04);
        rx_avail = 1; mcr_irq_en = 0; settle();
        chk("R9 status without master", isr_q, 8'h04);
        chk("R9 irq_n held high", {7'd0, irq_n}, 8'h01);
        mcr_irq_en = 1; settle();
        chk("R9 irq_n low", {7'd0, irq_n}, 8'h00);
    endtask

    task automatic t_idle();
        quiet(); wr_ier(8'h10);
        fifo_en = 1; rx_trig = 1; rx_avail = 1; thr_empty = 1; modem_chg = 1;
        settle();
        chk("R10 idle status", isr_q, 8'h01);
        chk("R10 idle irq_n", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_sleep();
        quiet();
        rx_avail = 1;
        wr_ier(8'h10);
        @(negedge clk); settle();
        chk("R11 sleep granted", {7'd0, sleep_active}, 8'h01);
        wr_ier(8'h14);
        @(negedge clk); settle();
        chk("R11 sleep blocked", {7'd0, sleep_active}, 8'h00);
        rx_avail = 0;
        @(negedge clk); settle();
        chk("R11 sleep resumes", {7'd0, sleep_active}, 8'h01);
        chk("R11 ier kept", ier_q, 8'h14);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ier();
        t_rxtrig();
        t_rxavail();
        t_thr();
        t_modem();
        t_xoff_single();
        t_xoff_pair();
        t_prio();
        t_master();
        t_idle();
        t_sleep();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule